// File: doc/BRIEF.md
# Byte-Wide I2C Register Target

This block is a standard-mode I2C target that lets a bus host read and write a flat space of 256 byte-wide registers. The registers themselves live outside the block. A single-cycle write strobe carries a register address and a data byte out of the block. A read-address output and a read-data input let the block fetch the byte it has to send. The block does not assign a meaning to any register.

SCL and SDA are oversampled by a much faster system clock. Each line passes through a synchronizer, and edge detection then finds clock edges, START and STOP.

The host first writes a one-byte register pointer. Any further bytes in the same write go to consecutive registers. To read, the host writes the pointer, issues a repeated START and then reads. The pointer advances each time the host acknowledges a byte.

The seven-bit device address is a fixed `10101` followed by two strap inputs, so up to four devices can share one bus. The block only pulls SDA low or releases it, so the SDA pad is driven open-drain.

Top module: `i2c_reg_target`

## Requirements
- R1: The block answers only the seven-bit address {1,0,1,0,1,addrStrap[1],addrStrap[0]} (MSB first on the wire). Any other address gets no acknowledge, and the rest of that transfer causes no write and no SDA drive.
- R2: A START or repeated START is SDA falling while SCL is high. It aborts whatever byte is in progress and makes the next eight bits an address byte.
- R3: A STOP is SDA rising while SCL is high. It returns the block to idle with SDA released, and clock pulses that follow without a START are ignored.
- R4: In a write transfer, the first byte after the address sets the register pointer. Each later byte produces a one-cycle wrStrobe, with wrAddr equal to the pointer and wrData equal to the byte.
- R5: After each written byte the pointer advances by one, wrapping from 0xFF to 0x00.
- R6: After a repeated START with the read bit set (address LSB = 1), the block shifts out the byte on rdData for rdAddr = pointer, MSB first. rdAddr always shows the pointer.
- R7: When the host acknowledges a read byte, the pointer advances and the next byte follows. After a host NACK, the pointer stays put and SDA stays released until START or STOP.
- R8: sdaDriveLow changes only while SCL is low.
- R9: After reset, sdaDriveLow and wrStrobe are low and the pointer (rdAddr) is 0x00.
- R10: For every byte the block receives while addressed (the address itself, the pointer, the data), it pulls SDA low during the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| addrStrap | input | 2 | Low two bits of the device address |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaDriveLow | output | 1 | 1 pulls SDA low; 0 releases it |
| wrStrobe | output | 1 | One-cycle register write pulse |
| wrAddr | output | 8 | Register address for the write |
| wrData | output | 8 | Data byte for the write |
| rdAddr | output | 8 | Register pointer, used as the read address |
| rdData | input | 8 | Register contents at rdAddr |

## Verification
The assertions assume a host that obeys the bus rules. It changes SDA only while SCL is low, except to make START and STOP. Each SCL level lasts many system clocks, so every edge is seen after synchronization before the next one arrives. The bench master holds every SCL phase for at least eight system clocks. It changes its own SDA a quarter bit-time after SCL falls, while the target changes its drive within a few clocks of that fall. The bus level seen by the block is the AND of the master's SDA and the target's inverted drive, just as a pull-up would make it.

// File: rtl/i2c_rt_pkg.sv
package i2c_rt_pkg;
  localparam int BYTE_W   = 8;
  localparam int REG_AW   = 8;
  localparam int CNT_W    = $clog2(BYTE_W + 1);
  localparam int DEV_HI_W = 5;
  localparam logic [DEV_HI_W-1:0] DEV_HI = 5'b10101;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK
  } rtState_t;

  typedef enum logic [1:0] {
    K_ADDR, K_REG, K_DATA
  } byteKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic countBit;
    logic clrCnt;
    logic loadTx;
    logic shiftOut;
    logic setPtr;
    logic incPtr;
    logic wrStb;
  } dpCtl_t;

  // bus events from datapath to control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startDet;
    logic stopDet;
    logic sdaLvl;
    logic sclLvl;
  } busEv_t;
endpackage

// File: rtl/i2c_rt_datapath.sv
module i2c_rt_datapath
  import i2c_rt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCtl_t            ctl,
  input  logic [BYTE_W-1:0] rdData,
  output busEv_t            ev,
  output logic [BYTE_W-1:0] rxByte,
  output logic [CNT_W-1:0]  bitCnt,
  output logic              txBit,
  output logic [REG_AW-1:0] rdAddr,
  output logic              wrStrobe,
  output logic [REG_AW-1:0] wrAddr,
  output logic [BYTE_W-1:0] wrData
);
  logic [SYNC_STAGES-1:0] sclSh, sdaSh;
  logic sclPrev, sdaPrev, sclNow, sdaNow;
  logic [BYTE_W-1:0] shiftReg;
  logic [REG_AW-1:0] ptr;

  assign sclNow = sclSh[SYNC_STAGES-1];
  assign sdaNow = sdaSh[SYNC_STAGES-1];

  // synchronizers reset to the idle (released) bus level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSh   <= '1;
      sdaSh   <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSh   <= {sclSh[SYNC_STAGES-2:0], sclIn};
      sdaSh   <= {sdaSh[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  always_comb begin
    ev.sclRise  = sclNow & ~sclPrev;
    ev.sclFall  = ~sclNow & sclPrev;
    ev.startDet = sclNow & sclPrev & sdaPrev & ~sdaNow;
    ev.stopDet  = sclNow & sclPrev & ~sdaPrev & sdaNow;
    ev.sdaLvl   = sdaNow;
    ev.sclLvl   = sclNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      ptr      <= '0;
      wrStrobe <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
    end else begin
      if (ctl.loadTx)        shiftReg <= rdData;
      else if (ctl.shiftIn)  shiftReg <= {shiftReg[BYTE_W-2:0], sdaNow};
      else if (ctl.shiftOut) shiftReg <= {shiftReg[BYTE_W-2:0], 1'b1};

      if (ctl.clrCnt)        bitCnt <= '0;
      else if (ctl.countBit) bitCnt <= bitCnt + 1'b1;

      if (ctl.setPtr)        ptr <= shiftReg[REG_AW-1:0];
      else if (ctl.incPtr)   ptr <= ptr + 1'b1;

      wrStrobe <= ctl.wrStb;
      if (ctl.wrStb) begin
        wrAddr <= ptr;
        wrData <= shiftReg;
      end
    end
  end

  assign rxByte = shiftReg;
  assign txBit  = shiftReg[BYTE_W-1];
  assign rdAddr = ptr;

  p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);
  p_wr_ptr_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> (ptr == REG_AW'(wrAddr + 1'b1)));
endmodule

// File: rtl/i2c_rt_control.sv
module i2c_rt_control
  import i2c_rt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        addrStrap,
  input  busEv_t            ev,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [CNT_W-1:0]  bitCnt,
  input  logic              txBit,
  output dpCtl_t            ctl,
  output logic              sdaDriveLow
);
  rtState_t  state, stateNxt;
  byteKind_t kind, kindNxt;
  logic      isRead, isReadNxt;
  logic      hostNack, hostNackNxt;
  logic      bitFull, addrHit;

  assign bitFull = (bitCnt == CNT_W'(BYTE_W));
  assign addrHit = (rxByte[BYTE_W-1:1] == {DEV_HI, addrStrap});

  always_comb begin
    ctl         = '0;
    stateNxt    = state;
    kindNxt     = kind;
    isReadNxt   = isRead;
    hostNackNxt = hostNack;
    unique case (state)
      ST_IDLE: ;
      ST_RX: begin
        if (ev.sclRise) begin
          ctl.shiftIn  = 1'b1;
          ctl.countBit = 1'b1;
        end
        if (ev.sclFall && bitFull) begin
          unique case (kind)
            K_ADDR: begin
              if (addrHit) begin
                stateNxt  = ST_ACK;
                isReadNxt = rxByte[0];
              end else begin
                stateNxt = ST_IDLE;
              end
            end
            K_REG: begin
              ctl.setPtr = 1'b1;
              stateNxt   = ST_ACK;
            end
            default: begin
              ctl.wrStb  = 1'b1;
              ctl.incPtr = 1'b1;
              stateNxt   = ST_ACK;
            end
          endcase
        end
      end
      ST_ACK: begin
        if (ev.sclFall) begin
          ctl.clrCnt = 1'b1;
          if (kind == K_ADDR && isRead) begin
            ctl.loadTx = 1'b1;
            stateNxt   = ST_TX;
          end else begin
            stateNxt = ST_RX;
            kindNxt  = (kind == K_ADDR) ? K_REG : K_DATA;
          end
        end
      end
      ST_TX: begin
        if (ev.sclRise) ctl.countBit = 1'b1;
        if (ev.sclFall) begin
          if (bitFull) stateNxt = ST_MACK;
          else         ctl.shiftOut = 1'b1;
        end
      end
      ST_MACK: begin
        if (ev.sclRise) begin
          hostNackNxt = ev.sdaLvl;
          ctl.incPtr  = ~ev.sdaLvl;
        end
        if (ev.sclFall) begin
          if (!hostNack) begin
            ctl.loadTx = 1'b1;
            ctl.clrCnt = 1'b1;
            stateNxt   = ST_TX;
          end else begin
            stateNxt = ST_IDLE;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase

    if (ev.stopDet) begin
      ctl      = '0;
      stateNxt = ST_IDLE;
    end
    if (ev.startDet) begin
      ctl        = '0;
      ctl.clrCnt = 1'b1;
      stateNxt   = ST_RX;
      kindNxt    = K_ADDR;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      kind     <= K_ADDR;
      isRead   <= 1'b0;
      hostNack <= 1'b1;
    end else begin
      state    <= stateNxt;
      kind     <= kindNxt;
      isRead   <= isReadNxt;
      hostNack <= hostNackNxt;
    end
  end

  assign sdaDriveLow = (state == ST_ACK) || (state == ST_TX && !txBit);

  p_sda_scl_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !ev.sclLvl);
  p_idle_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    ev.stopDet |=> !sdaDriveLow);
  p_start_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    ev.startDet |=> (state == ST_RX && kind == K_ADDR && bitCnt == '0));
  p_ack_ninth_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACK) |-> bitFull);
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_rt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        addrStrap,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  output logic              wrStrobe,
  output logic [REG_AW-1:0] wrAddr,
  output logic [BYTE_W-1:0] wrData,
  output logic [REG_AW-1:0] rdAddr,
  input  logic [BYTE_W-1:0] rdData
);
  dpCtl_t            ctl;
  busEv_t            ev;
  logic [BYTE_W-1:0] rxByte;
  logic [CNT_W-1:0]  bitCnt;
  logic              txBit;

  i2c_rt_control u_ctrl (
    .clk(clk), .rstN(rstN), .addrStrap(addrStrap), .ev(ev),
    .rxByte(rxByte), .bitCnt(bitCnt), .txBit(txBit),
    .ctl(ctl), .sdaDriveLow(sdaDriveLow)
  );

  i2c_rt_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ctl(ctl),
    .rdData(rdData), .ev(ev), .rxByte(rxByte), .bitCnt(bitCnt),
    .txBit(txBit), .rdAddr(rdAddr), .wrStrobe(wrStrobe),
    .wrAddr(wrAddr), .wrData(wrData)
  );
endmodule

// File: tb/test_i2c_reg_target.sv
`timescale 1ns/1ps
module test_i2c_reg_target;
  localparam int Q = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rstN;
  logic [1:0] strap;
  logic       sclM = 1'b1, sdaM = 1'b1;
  logic       sdaDriveLow, wrStrobe;
  logic [7:0] wrAddr, wrData, rdAddr, rdData;
  wire        sdaBus = sdaM & ~sdaDriveLow;

  logic [7:0] regs [256];
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];
  int errs = 0, checks = 0, wrCount = 0, r8Viol = 0;
  logic prevDrive = 1'b0, prevScl = 1'b1;

  assign rdData = regs[rdAddr];

  i2c_reg_target i_i2c_reg_target (
    .clk(clk), .rstN(rstN), .addrStrap(strap), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow), .wrStrobe(wrStrobe), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );

  // register file model and R8 bus monitor
  always @(negedge clk) begin
    if (wrStrobe) begin
      regs[wrAddr] <= wrData;
      wrCount <= wrCount + 1;
    end
    if (rstN && sdaDriveLow != prevDrive && prevScl) r8Viol <= r8Viol + 1;
    prevDrive <= sdaDriveLow;
    prevScl   <= sclM;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic q(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic startCond();
    sdaM = 1'b1; q(1); sclM = 1'b1; q(2); sdaM = 1'b0; q(2); sclM = 1'b0; q(1);
  endtask

  task automatic stopCond();
    sdaM = 1'b0; q(1); sclM = 1'b1; q(2); sdaM = 1'b1; q(2);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; q(1); sclM = 1'b1; q(2); sclM = 1'b0; q(1);
    end
    sdaM = 1'b1; q(1); sclM = 1'b1; q(1); ack = ~sdaBus; q(1); sclM = 1'b0; q(1);
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(1); sclM = 1'b1; q(1); b[i] = sdaBus; q(1); sclM = 1'b0; q(1);
    end
    sdaM = nack; q(1); sclM = 1'b1; q(2); sclM = 1'b0; q(1); sdaM = 1'b1;
  endtask

  task automatic doWrite(input logic [6:0] dev, input logic [7:0] ptr,
                         input int n, output logic allAck);
    logic a;
    startCond();
    sendByte({dev, 1'b0}, a); allAck = a;
    sendByte(ptr, a); allAck &= a;
    for (int k = 0; k < n; k++) begin
      sendByte(wbuf[k], a); allAck &= a;
    end
    stopCond();
  endtask

  task automatic doRead(input logic [6:0] dev, input logic [7:0] ptr, input int n);
    logic a;
    startCond();
    sendByte({dev, 1'b0}, a);
    sendByte(ptr, a);
    startCond();
    sendByte({dev, 1'b1}, a);
    for (int k = 0; k < n; k++) recvByte(k == n - 1, rbuf[k]);
  endtask

  initial begin
    repeat (190000) @(negedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic a, acc;
    logic [7:0] b;
    int w0, lowSeen;
    for (int i = 0; i < 256; i++) regs[i] = 8'h00;
    strap = 2'b00;
    rstN = 1'b0;
    repeat (5) @(negedge clk);
    chk(sdaDriveLow == 1'b0, "R9 drive", sdaDriveLow, 0);
    chk(wrStrobe == 1'b0, "R9 strobe", wrStrobe, 0);
    chk(rdAddr == 8'h00, "R9 pointer", rdAddr, 0);
    rstN = 1'b1;
    q(2);

    // R1 / R10 sweep over straps and nearby addresses
    for (int s = 0; s < 4; s++) begin
      strap = s[1:0];
      for (int d = 8'h50; d < 8'h60; d++) begin
        logic hit;
        hit = (d == (8'h54 + s));
        w0 = wrCount;
        startCond();
        sendByte({d[6:0], 1'b0}, a);
        chk(a == hit, $sformatf("R1 R10 ack dev=%0h strap=%0d", d, s), a, hit);
        sendByte(8'h10, acc);
        sendByte(8'h33, acc);
        stopCond();
        q(1);
        chk((wrCount - w0) == (hit ? 1 : 0), "R1 write count", wrCount - w0, hit ? 1 : 0);
      end
    end

    strap = 2'b10;  // device address 0x56
    // R4 R5 burst of computed values from 0x80
    for (int i = 0; i < 16; i++) wbuf[i] = 8'((i * 37 + 5) & 255);
    w0 = wrCount;
    doWrite(7'h56, 8'h80, 16, acc);
    q(1);
    chk(acc == 1'b1, "R10 burst acks", acc, 1);
    chk((wrCount - w0) == 16, "R4 burst strobes", wrCount - w0, 16);
    for (int i = 0; i < 16; i++) begin
      doRead(7'h56, 8'(8'h80 + i), 1);
      stopCond();
      chk(rbuf[0] == 8'((i * 37 + 5) & 255), "R6 single read", rbuf[0], (i * 37 + 5) & 255);
    end

    // R5 wrap and R7 continued read with NACK
    for (int i = 0; i < 4; i++) wbuf[i] = 8'(8'hC1 + i);
    doWrite(7'h56, 8'hFE, 4, acc);
    chk(regs[8'h00] == 8'hC3 && regs[8'h01] == 8'hC4, "R5 wrap", regs[8'h00], 8'hC3);
    doRead(7'h56, 8'hFE, 4);
    for (int i = 0; i < 4; i++)
      chk(rbuf[i] == 8'(8'hC1 + i), "R7 burst read", rbuf[i], 8'hC1 + i);
    chk(rdAddr == 8'h01, "R7 pointer after nack", rdAddr, 1);
    recvByte(1'b1, b);
    chk(b == 8'hFF, "R7 released after nack", b, 8'hFF);
    stopCond();

    // R2 repeated START between transfers
    startCond();
    sendByte({7'h56, 1'b0}, a); sendByte(8'h40, a); sendByte(8'h11, a);
    startCond();
    sendByte({7'h56, 1'b0}, a); sendByte(8'h41, a); sendByte(8'h22, a);
    stopCond();
    chk(regs[8'h40] == 8'h11 && regs[8'h41] == 8'h22, "R2 restart write", regs[8'h41], 8'h22);

    // R2 START inside a partial byte
    startCond();
    sendByte({7'h56, 1'b0}, a); sendByte(8'h50, a);
    for (int i = 0; i < 3; i++) begin
      sdaM = 1'b0; q(1); sclM = 1'b1; q(2); sclM = 1'b0; q(1);
    end
    startCond();
    sendByte({7'h56, 1'b0}, a);
    chk(a == 1'b1, "R2 address after mid-byte start", a, 1);
    sendByte(8'h51, a); sendByte(8'h77, a);
    stopCond();
    chk(regs[8'h50] == 8'h00, "R2 aborted byte not written", regs[8'h50], 0);
    chk(regs[8'h51] == 8'h77, "R2 write after restart", regs[8'h51], 8'h77);

    // R3 STOP then clocks without START
    startCond();
    sendByte({7'h56, 1'b0}, a);
    stopCond();
    chk(sdaDriveLow == 1'b0, "R3 released after stop", sdaDriveLow, 0);
    w0 = wrCount;
    sclM = 1'b0; q(1);
    sendByte({7'h56, 1'b0}, a);
    chk(a == 1'b0, "R3 no ack without start", a, 0);
    sendByte(8'h60, a); sendByte(8'h99, a);
    stopCond();
    chk(wrCount == w0, "R3 no write without start", wrCount - w0, 0);

    // R1 read with a foreign address: bus stays high
    startCond();
    sendByte({7'h54, 1'b1}, a);
    chk(a == 1'b0, "R1 foreign read no ack", a, 0);
    lowSeen = 0;
    recvByte(1'b1, b);
    if (b != 8'hFF) lowSeen = 1;
    chk(lowSeen == 0, "R1 foreign read no drive", b, 8'hFF);
    stopCond();

    chk(r8Viol == 0, "R8 drive change under high SCL", r8Viol, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule